// File: doc/BRIEF.md
# On-chip XDATA access router

This block steers the external-data reads and writes of a small 8-bit microcontroller core. The core may carry an optional 1 KB on-chip data RAM that sits at the top of the 64 KB data space, at addresses 0xFC00 to 0xFFFF. For every access the router decides which of the two serves it: the on-chip RAM or the external bus. It also decides whether the external read and write strobes move during an on-chip access.

A two-bit control register in special-function space sets both decisions. One bit is a global switch that sends every access to the external bus. The other bit, when on-chip service is active, copies internal accesses onto the external strobes and address bus. Such a copy lets an external analyser or a shadow memory follow them. Every access takes exactly one cycle after it is presented.

Top module: `xdat_router`

## Requirements
- R1: After reset the control register reads 0xFD at SFR address 0xB1: bit 0 (map-off) = 1, bit 1 (mirror) = 0, and the upper six bits read as 1. No done pulse, strobe or data drive is active.
- R2: An SFR write to 0xB1 stores write-data bits [1:0] into the control register. A read of 0xB1 returns them in [1:0] with ones above. A read of any other SFR address returns 0x00, and writes to other addresses leave the control register unchanged.
- R3: While map-off = 1, every access runs an external bus cycle with its strobe, and a write leaves the on-chip RAM unchanged.
- R4: While map-off = 0, an access whose address bits [15:10] are all ones is served by the on-chip RAM. Read data then comes from the RAM and not from the external data bus.
- R5: While map-off = 0 and mirror = 0, an on-chip access keeps both ext_rd_n and ext_wr_n high.
- R6: While map-off = 0 and mirror = 1, an on-chip read drives ext_rd_n low and an on-chip write drives ext_wr_n low for the access cycle, with ext_addr showing the access address.
- R7: An access whose address bits [15:10] are not all ones always runs an external bus cycle with its strobe, whatever the mirror bit holds.
- R8: rsp_done pulses for exactly the one cycle after the cycle in which req_valid is high. Any strobe is low only in that cycle, and ext_rd_n and ext_wr_n are never low together.
- R9: ext_dq_oe is high, with ext_dq_o carrying the write data, exactly in the cycles where ext_wr_n is low.
- R10: Routing uses the control bits held in the cycle the request is presented. An SFR write in that same cycle applies only to later accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request from the core |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Data-space address |
| req_wdata | input | 8 | Write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Read data, valid with rsp_done on a read |
| sfr_we | input | 1 | SFR write strobe |
| sfr_addr | input | 8 | SFR address |
| sfr_wdata | input | 8 | SFR write data |
| sfr_rdata | output | 8 | SFR read data (combinational) |
| ext_addr | output | 16 | External address bus |
| ext_dq_o | output | 8 | External data out |
| ext_dq_oe | output | 1 | External data drive enable |
| ext_dq_i | input | 8 | External data in |
| ext_rd_n | output | 1 | External read strobe, active low |
| ext_wr_n | output | 1 | External write strobe, active low |

## Verification
On every cycle the assertions check several rules. A done pulse follows each request and only a request. The two strobes never overlap. The data drive never appears without a write strobe. Out-of-range and map-off accesses always strobe, quiet on-chip accesses never do, and a mirrored access shows its address. Some behaviour only the bench's sweeps can show. These are that on-chip read data comes from the RAM rather than the bus, and that writes made while the RAM is switched off leave its contents alone. They also cover the register read-back format and the same-cycle ordering between an SFR write and a request.

// File: rtl/xdat_pkg.sv
package xdat_pkg;
   // Per-access steering decision carried into the access cycle.
   typedef struct packed {
      logic we;      // write access
      logic intl;    // served by on-chip RAM
      logic strobe;  // external strobe fires
   } xdat_route_t;

   localparam int unsigned CTRL_BITS = 2;
   localparam logic [CTRL_BITS-1:0] CTRL_RESET = 2'b01;
endpackage

// File: rtl/xdat_ctrl_reg.sv
module xdat_ctrl_reg #(
   parameter int unsigned SFR_AW = 8,
   parameter int unsigned DATA_W = 8,
   parameter logic [SFR_AW-1:0] CTRL_ADDR = 8'hB1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sfr_we,
   input  logic [SFR_AW-1:0] sfr_addr,
   input  logic [DATA_W-1:0] sfr_wdata,
   output logic [DATA_W-1:0] sfr_rdata,
   output logic              map_off,
   output logic              mirror
);
   import xdat_pkg::*;

   if (DATA_W < CTRL_BITS) begin : g_bad_w
      $error("xdat_ctrl_reg: DATA_W must hold the control bits");
   end

   logic [CTRL_BITS-1:0] ctrl_q;
   logic                 hit;
   logic                 unused_hi;

   assign hit       = (sfr_addr == CTRL_ADDR);
   assign unused_hi = ^sfr_wdata[DATA_W-1:CTRL_BITS];

   always_ff @(posedge clk) begin
      if (!rst_n)              ctrl_q <= CTRL_RESET;
      else if (sfr_we && hit)  ctrl_q <= sfr_wdata[CTRL_BITS-1:0];
   end

   always_comb begin
      sfr_rdata = '0;
      if (hit) sfr_rdata = {{(DATA_W-CTRL_BITS){1'b1}}, ctrl_q};
   end

   assign map_off = ctrl_q[0];
   assign mirror  = ctrl_q[1];
endmodule

// File: rtl/xdat_route_dec.sv
module xdat_route_dec #(
   parameter int unsigned ADDR_W   = 16,
   parameter int unsigned LOC_AW   = 10,
   parameter bit          HAS_XRAM = 1'b1
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              map_off,
   input  logic              mirror,
   output logic              use_int,
   output logic              drive_stb
);
   localparam int unsigned WIN_W = ADDR_W - LOC_AW;

   logic in_win;

   if (HAS_XRAM) begin : g_win
      assign in_win  = &addr[ADDR_W-1:LOC_AW];
      assign use_int = in_win && !map_off;
   end else begin : g_nowin
      logic unused_dec;
      assign unused_dec = ^{addr[ADDR_W-1:LOC_AW], map_off};
      assign in_win  = 1'b0;
      assign use_int = 1'b0;
   end

   // Mirror bit only matters for on-chip service.
   assign drive_stb = !use_int || mirror;

   logic unused_lo;
   assign unused_lo = ^{addr[LOC_AW-1:0], in_win, WIN_W[0]};
endmodule

// File: rtl/xdat_ram.sv
module xdat_ram #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned LOC_AW = 10
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [LOC_AW-1:0] idx,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] q
);
   localparam int unsigned DEPTH = 1 << LOC_AW;

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) mem[idx] <= wdata;
      if (rd_en) q <= mem[idx];
   end
endmodule

// File: rtl/xdat_router.sv
module xdat_router #(
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned LOC_AW    = 10,
   parameter int unsigned SFR_AW    = 8,
   parameter logic [SFR_AW-1:0] CTRL_ADDR = 8'hB1,
   parameter bit          HAS_XRAM  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_we,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_done,
   output logic [DATA_W-1:0] rsp_rdata,
   input  logic              sfr_we,
   input  logic [SFR_AW-1:0] sfr_addr,
   input  logic [DATA_W-1:0] sfr_wdata,
   output logic [DATA_W-1:0] sfr_rdata,
   output logic [ADDR_W-1:0] ext_addr,
   output logic [DATA_W-1:0] ext_dq_o,
   output logic              ext_dq_oe,
   input  logic [DATA_W-1:0] ext_dq_i,
   output logic              ext_rd_n,
   output logic              ext_wr_n
);
   import xdat_pkg::*;

   if (LOC_AW >= ADDR_W) begin : g_bad_aw
      $error("xdat_router: LOC_AW must be below ADDR_W");
   end
   if (DATA_W < 2) begin : g_bad_dw
      $error("xdat_router: DATA_W too small");
   end

   logic map_off, mirror;
   logic use_int, drive_stb;

   xdat_ctrl_reg #(.SFR_AW(SFR_AW), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .sfr_we    (sfr_we),
      .sfr_addr  (sfr_addr),
      .sfr_wdata (sfr_wdata),
      .sfr_rdata (sfr_rdata),
      .map_off   (map_off),
      .mirror    (mirror)
   );

   xdat_route_dec #(.ADDR_W(ADDR_W), .LOC_AW(LOC_AW), .HAS_XRAM(HAS_XRAM)) u_dec (
      .addr      (req_addr),
      .map_off   (map_off),
      .mirror    (mirror),
      .use_int   (use_int),
      .drive_stb (drive_stb)
   );

   // Access-cycle stage
   logic              act_q;
   xdat_route_t       rt_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_q   <= 1'b0;
         rt_q    <= '0;
         addr_q  <= '0;
         wdata_q <= '0;
      end else begin
         act_q <= req_valid;
         if (req_valid) begin
            rt_q.we     <= req_we;
            rt_q.intl   <= use_int;
            rt_q.strobe <= drive_stb;
            addr_q      <= req_addr;
            wdata_q     <= req_wdata;
         end
      end
   end

   logic [DATA_W-1:0] ram_q;

   if (HAS_XRAM) begin : g_ram
      xdat_ram #(.DATA_W(DATA_W), .LOC_AW(LOC_AW)) u_ram (
         .clk   (clk),
         .wr_en (req_valid && req_we && use_int),
         .rd_en (req_valid && !req_we && use_int),
         .idx   (req_addr[LOC_AW-1:0]),
         .wdata (req_wdata),
         .q     (ram_q)
      );
   end else begin : g_noram
      assign ram_q = '0;
   end

   logic rd_cyc, wr_cyc;
   assign rd_cyc = act_q && !rt_q.we;
   assign wr_cyc = act_q &&  rt_q.we;

   assign rsp_done  = act_q;
   assign rsp_rdata = rd_cyc ? (rt_q.intl ? ram_q : ext_dq_i) : '0;
   assign ext_addr  = addr_q;
   assign ext_rd_n  = !(rd_cyc && rt_q.strobe);
   assign ext_wr_n  = !(wr_cyc && rt_q.strobe);
   assign ext_dq_oe = wr_cyc && rt_q.strobe;
   assign ext_dq_o  = wdata_q;
endmodule

// File: rtl/xdat_router_chk.sv
module xdat_router_chk #(
   parameter int unsigned ADDR_W   = 16,
   parameter int unsigned LOC_AW   = 10,
   parameter bit          HAS_XRAM = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_we,
   input logic [ADDR_W-1:0] req_addr,
   input logic              rsp_done,
   input logic              ext_rd_n,
   input logic              ext_wr_n,
   input logic              ext_dq_oe,
   input logic [ADDR_W-1:0] ext_addr,
   input logic              map_off,
   input logic              mirror
);
   logic in_win;
   assign in_win = HAS_XRAM && (req_addr[ADDR_W-1:LOC_AW] == {(ADDR_W-LOC_AW){1'b1}});

   a_r8_done_after_req: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_done);
   a_r8_no_spurious_done: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_done);
   a_r8_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(!ext_rd_n && !ext_wr_n));
   a_r8_strobe_only_in_done: assert property (@(posedge clk) disable iff (!rst_n)
      (!ext_rd_n || !ext_wr_n) |-> rsp_done);
   a_r9_drive_needs_wr: assert property (@(posedge clk) disable iff (!rst_n)
      ext_dq_oe |-> !ext_wr_n);
   a_r7_outside_strobes: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !in_win) |=> (!ext_rd_n || !ext_wr_n));
   a_r3_map_off_strobes: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && map_off) |=> (!ext_rd_n || !ext_wr_n));
   a_r5_quiet_internal: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && in_win && !map_off && !mirror) |=> (ext_rd_n && ext_wr_n));
   a_r6_mirror_addr: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && in_win && !map_off && mirror) |=>
         (ext_addr == $past(req_addr) && (ext_rd_n != ext_wr_n)));
   a_r6_mirror_dir: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && in_win && !map_off && mirror && req_we) |=> !ext_wr_n);
endmodule

bind xdat_router xdat_router_chk #(
   .ADDR_W(ADDR_W), .LOC_AW(LOC_AW), .HAS_XRAM(HAS_XRAM)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_we    (req_we),
   .req_addr  (req_addr),
   .rsp_done  (rsp_done),
   .ext_rd_n  (ext_rd_n),
   .ext_wr_n  (ext_wr_n),
   .ext_dq_oe (ext_dq_oe),
   .ext_addr  (ext_addr),
   .map_off   (map_off),
   .mirror    (mirror)
);

// File: tb/xdat_router_tb.sv
`timescale 1ns/1ps
module xdat_router_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_we = 1'b0;
   logic [15:0] req_addr = '0;
   logic [7:0]  req_wdata = '0;
   logic        rsp_done;
   logic [7:0]  rsp_rdata;
   logic        sfr_we = 1'b0;
   logic [7:0]  sfr_addr = '0, sfr_wdata = '0, sfr_rdata;
   logic [15:0] ext_addr;
   logic [7:0]  ext_dq_o, ext_dq_i;
   logic        ext_dq_oe, ext_rd_n, ext_wr_n;

   always #4 clk = ~clk;   // 125 MHz

   xdat_router u_dut (.*);

   function automatic logic [7:0] bus_val(input logic [15:0] a);
      return a[7:0] ^ a[15:8] ^ 8'h5A;
   endfunction
   assign ext_dq_i = bus_val(ext_addr);

   int checks = 0, failures = 0;
   logic [7:0] ram_m [1024];
   bit         ram_ok [1024];
   logic       m0 = 1'b1, m1 = 1'b0;
   bit         done_flag = 1'b0;

   task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
      end
   endtask

   task automatic sfr_wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk); sfr_we = 1'b1; sfr_addr = a; sfr_wdata = d;
      @(negedge clk); sfr_we = 1'b0;
      if (a == 8'hB1) begin m0 = d[0]; m1 = d[1]; end
   endtask

   task automatic sfr_rd_chk(input logic [7:0] a, input logic [7:0] exp, input string tag);
      @(negedge clk); sfr_addr = a; #1;
      chk(sfr_rdata === exp, tag, sfr_rdata, exp);
   endtask

   task automatic access(input logic [15:0] a, input logic w, input logic [7:0] d, input string tag);
      logic intl, stb;
      logic [7:0] er;
      intl = !m0 && (a[15:10] == 6'h3F);
      stb  = !intl || m1;
      er   = intl ? ram_m[a[9:0]] : bus_val(a);
      @(negedge clk); req_valid = 1'b1; req_we = w; req_addr = a; req_wdata = d;
      @(negedge clk); req_valid = 1'b0;
      chk(rsp_done === 1'b1, {tag, " R8 done"}, rsp_done, 1);
      chk(ext_rd_n === !(stb && !w), {tag, " rd_n"}, ext_rd_n, !(stb && !w));
      chk(ext_wr_n === !(stb && w), {tag, " wr_n"}, ext_wr_n, !(stb && w));
      if (stb) chk(ext_addr === a, {tag, " R6 ext_addr"}, ext_addr, a);
      if (w) begin
         chk(ext_dq_oe === stb, {tag, " R9 oe"}, ext_dq_oe, stb);
         if (stb) chk(ext_dq_o === d, {tag, " R9 dq_o"}, ext_dq_o, d);
      end else if (!intl || ram_ok[a[9:0]]) begin
         chk(rsp_rdata === er, {tag, " R4 rdata"}, rsp_rdata, er);
      end
      if (intl && w) begin ram_m[a[9:0]] = d; ram_ok[a[9:0]] = 1'b1; end
      @(negedge clk);
      chk(rsp_done === 1'b0 && ext_rd_n === 1'b1 && ext_wr_n === 1'b1 && ext_dq_oe === 1'b0,
          {tag, " R8 one cycle"}, {rsp_done, ext_rd_n, ext_wr_n, ext_dq_oe}, 4'b0110);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done_flag) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin : main
      logic [15:0] outs [6];
      outs = '{16'h0000, 16'h0123, 16'h7FFF, 16'h8000, 16'hFBFF, 16'hF800};
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(rsp_done === 1'b0 && ext_rd_n === 1'b1 && ext_wr_n === 1'b1 && ext_dq_oe === 1'b0,
          "R1 idle outputs", {rsp_done, ext_rd_n, ext_wr_n, ext_dq_oe}, 4'b0110);
      sfr_rd_chk(8'hB1, 8'hFD, "R1 ctrl reset");

      // R2 register access
      for (int v = 0; v < 4; v++) begin
         sfr_wr(8'hB1, 8'hA0 | 8'(v));
         sfr_rd_chk(8'hB1, 8'hFC | 8'(v), "R2 readback");
      end
      sfr_wr(8'hB1, 8'h02);
      sfr_wr(8'h80, 8'hFF);
      sfr_rd_chk(8'h80, 8'h00, "R2 other addr reads 0");
      sfr_rd_chk(8'hB1, 8'hFE, "R2 other write ignored");

      // Fill whole on-chip RAM quietly (R5)
      sfr_wr(8'hB1, 8'h00);
      for (int i = 0; i < 1024; i++)
         access(16'hFC00 | 16'(i), 1'b1, 8'(i) ^ 8'({i[9:8], 6'h0}) ^ 8'h3C, "R5 fill");
      // Read back with mirrored strobes (R6, R4)
      sfr_wr(8'hB1, 8'h02);
      for (int i = 0; i < 1024; i++)
         access(16'hFC00 | 16'(i), 1'b0, 8'h00, "R6 mirror read");
      for (int i = 0; i < 16; i++)
         access(16'hFFF0 | 16'(i), 1'b1, 8'(8'hC0 + i), "R6 mirror write");
      // Quiet reads (R5)
      sfr_wr(8'hB1, 8'h00);
      for (int i = 0; i < 64; i++)
         access(16'hFC00 | 16'(i * 16), 1'b0, 8'h00, "R5 quiet read");

      // R3: map-off sends everything out, RAM untouched
      for (int v = 1; v < 4; v += 2) begin
         sfr_wr(8'hB1, 8'(v));
         for (int i = 0; i < 32; i++) begin
            access(16'hFC10 | 16'(i), 1'b1, 8'hEE, "R3 map-off write");
            access(16'hFC10 | 16'(i), 1'b0, 8'h00, "R3 map-off read");
         end
      end
      sfr_wr(8'hB1, 8'h00);
      for (int i = 0; i < 32; i++)
         access(16'hFC10 | 16'(i), 1'b0, 8'h00, "R3 RAM untouched");

      // R7 out-of-range under every control value
      for (int v = 0; v < 4; v++) begin
         sfr_wr(8'hB1, 8'(v));
         foreach (outs[k]) begin
            access(outs[k], 1'b0, 8'h00, "R7 out-of-range read");
            access(outs[k], 1'b1, 8'(k * 7), "R7 out-of-range write");
         end
      end

      // R10 same-cycle SFR write does not affect current access
      sfr_wr(8'hB1, 8'h01);
      @(negedge clk);
      sfr_we = 1'b1; sfr_addr = 8'hB1; sfr_wdata = 8'h00;
      req_valid = 1'b1; req_we = 1'b0; req_addr = 16'hFC05;
      @(negedge clk);
      sfr_we = 1'b0; req_valid = 1'b0;
      chk(ext_rd_n === 1'b0, "R10 old map-off routes out", ext_rd_n, 0);
      chk(rsp_rdata === bus_val(16'hFC05), "R10 bus data", rsp_rdata, bus_val(16'hFC05));
      m0 = 1'b0; m1 = 1'b0;
      access(16'hFC05, 1'b0, 8'h00, "R10 next access internal");

      done_flag = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule